// File: doc/BRIEF.md
# Majority-Gate Cascade Magnitude Comparator

This block compares two unsigned N-bit operands and raises exactly one of three flags: operand A greater, operand A less, or operands equal. All of its logic is written as 3-input majority functions and inverters. A two-input AND is a majority gate with one input tied low, and a two-input OR is a majority gate with one input tied high. The aim is a netlist that maps one to one onto a technology whose only native gate is the majority gate.

The comparison runs as a ripple chain of N identical one-bit stages, from the least significant bit upward. A first level forms, for every bit at once, the terms "this bit says greater" and "this bit does not say less", and the mirror pair for less. Stage i then takes the greater/less flags for the lower sub-word. It combines them with its own bit's terms in three majority levels, shaped as a three-majority universal gate, and hands the flags for bits i..0 to stage i+1. The plain chain yields only greater and less. A closing level forms equality as the AND of both flags inverted, which makes the block a full comparator.

The parameter PIPE selects between two builds. With PIPE = 0 the chain is purely combinational. With PIPE = 1 a register follows every majority level, so each level stands for one clock phase. A new operand pair enters every cycle and its result appears 3N+2 clock edges later.

Top module: `mgc_cmp`

## Requirements
- R1: Output gt is 1 exactly when a > b as unsigned N-bit numbers.
- R2: Output lt is 1 exactly when a < b as unsigned N-bit numbers.
- R3: Output eq is 1 exactly when a == b, including the all-zero and all-one operand pairs.
- R4: gt and lt are never 1 together, and once results are valid exactly one of gt, lt, eq is 1, so {gt,lt,eq} is one of 100, 010, 001.
- R5: With PIPE = 0 the outputs follow a and b combinationally, with no clock edge in the path.
- R6: With PIPE = 1 the result for the operands captured at a rising edge appears after the 3N+2-th rising edge, counting that edge, and a new operand pair is accepted at every edge.
- R7: rst is synchronous and active high; with PIPE = 1, at every edge where rst is 1 all pipeline registers clear, so gt, lt and eq read 0 while reset is held.
- R8: The most significant differing bit alone decides the result; for example a = 1000_0000, b = 0111_1111 gives gt, and the swapped pair gives lt.
- R9: When operands differ only in bit 0, that bit decides the result through the whole chain; for example a = 0000_0001, b = 0 gives gt, and a = 1111_1110, b = 1111_1111 gives lt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the level registers (unused when PIPE = 0) |
| rst | input | 1 | Synchronous active-high reset of the level registers |
| a | input | N | Operand A, unsigned |
| b | input | N | Operand B, unsigned |
| gt | output | 1 | A greater than B |
| lt | output | 1 | A less than B |
| eq | output | 1 | A equal to B |

## Verification
A broken bit term or a wrong stage flag is seen at the ports as a wrong gt or lt whenever that bit is the highest one that differs. In the pipelined build this shows 3N+2 edges after the offending pair enters. Operand pairs that differ only in the top bit or only in bit 0, and pairs that differ in one random bit, send such a fault to the outputs quickly. A flag chain that loses its exclusivity shows as two flags high at once in the same result. A shifted latency or a missed reset shows as results landing on the wrong cycle or as flags left high during reset.

// File: rtl/mgc_pkg.sv
package mgc_pkg;

    // greater / less pair carried along the bit chain
    typedef struct packed {
        logic gt;
        logic lt;
    } mgc_rel_t;

    // the only primitive: 3-input majority
    function automatic logic mgc_maj(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    // two-input AND: majority with one input tied low
    function automatic logic mgc_and(input logic x, input logic y);
        return mgc_maj(x, y, 1'b0);
    endfunction

    // two-input OR: majority with one input tied high
    function automatic logic mgc_or(input logic x, input logic y);
        return mgc_maj(x, y, 1'b1);
    endfunction

    // majority levels from operands to flags: term level, three per bit, equality level
    function automatic int mgc_levels(input int width);
        return 3 * width + 2;
    endfunction

endpackage

// File: rtl/mgc_lvl.sv
// One majority level boundary: a register when PIPE is set, a wire otherwise.
module mgc_lvl #(
    parameter int W    = 1,
    parameter int PIPE = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (PIPE != 0) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= d;
            end
        end else begin : g_wire
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/mgc_prep.sv
// First majority level: per-bit decision terms for every bit in parallel.
//   pg[i] = a[i] & ~b[i]   (bit says greater)
//   qg[i] = a[i] | ~b[i]   (bit does not say less)
//   pl/ql are the mirror terms for less.
module mgc_prep
    import mgc_pkg::*;
#(
    parameter int N    = 8,
    parameter int PIPE = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] pg,
    output logic [N-1:0] qg,
    output logic [N-1:0] pl,
    output logic [N-1:0] ql
);

    logic [N-1:0] pg_c, qg_c, pl_c, ql_c;

    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            assign pg_c[i] = mgc_and(a[i], ~b[i]);
            assign qg_c[i] = mgc_or(a[i], ~b[i]);
            assign pl_c[i] = mgc_and(~a[i], b[i]);
            assign ql_c[i] = mgc_or(~a[i], b[i]);
        end
    endgenerate

    mgc_lvl #(.W(4 * N), .PIPE(PIPE)) u_lvl (
        .clk (clk),
        .rst (rst),
        .d   ({pg_c, qg_c, pl_c, ql_c}),
        .q   ({pg, qg, pl, ql})
    );

endmodule

// File: rtl/mgc_stage.sv
// One bit of the cascade, three majority levels deep:
//   level 1: r   = AND(q[IDX], flag_in)
//   level 2: u0  = AND(p[IDX], q[IDX]),  u1 = OR(p[IDX], r)
//   level 3: out = OR(u0, u1)
// Levels 2 and 3 form the three-majority universal gate M(M(y1,y2,0),M(y1,y3,1),1).
module mgc_stage
    import mgc_pkg::*;
#(
    parameter int N    = 8,
    parameter int IDX  = 0,
    parameter int PIPE = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pg_i,
    input  logic [N-1:0] qg_i,
    input  logic [N-1:0] pl_i,
    input  logic [N-1:0] ql_i,
    input  mgc_rel_t     rel_i,
    output logic [N-1:0] pg_o,
    output logic [N-1:0] qg_o,
    output logic [N-1:0] pl_o,
    output logic [N-1:0] ql_o,
    output mgc_rel_t     rel_o
);

    localparam int VW = 4 * N;

    // ---- level 1: gate the incoming flag with "this bit does not oppose"
    logic          rg_c, rl_c;
    logic [N-1:0]  pg1, qg1, pl1, ql1;
    logic          rg1, rl1;

    assign rg_c = mgc_and(qg_i[IDX], rel_i.gt);
    assign rl_c = mgc_and(ql_i[IDX], rel_i.lt);

    mgc_lvl #(.W(VW + 2), .PIPE(PIPE)) u_l1 (
        .clk (clk),
        .rst (rst),
        .d   ({pg_i, qg_i, pl_i, ql_i, rg_c, rl_c}),
        .q   ({pg1, qg1, pl1, ql1, rg1, rl1})
    );

    // ---- level 2: inner majorities of the universal gate
    logic          ug0_c, ug1_c, ul0_c, ul1_c;
    logic [N-1:0]  pg2, qg2, pl2, ql2;
    logic          ug0, ug1, ul0, ul1;

    assign ug0_c = mgc_and(pg1[IDX], qg1[IDX]);
    assign ug1_c = mgc_or(pg1[IDX], rg1);
    assign ul0_c = mgc_and(pl1[IDX], ql1[IDX]);
    assign ul1_c = mgc_or(pl1[IDX], rl1);

    mgc_lvl #(.W(VW + 4), .PIPE(PIPE)) u_l2 (
        .clk (clk),
        .rst (rst),
        .d   ({pg1, qg1, pl1, ql1, ug0_c, ug1_c, ul0_c, ul1_c}),
        .q   ({pg2, qg2, pl2, ql2, ug0, ug1, ul0, ul1})
    );

    // ---- level 3: outer majority of the universal gate
    mgc_rel_t rel_c;

    assign rel_c.gt = mgc_maj(ug0, ug1, 1'b1);
    assign rel_c.lt = mgc_maj(ul0, ul1, 1'b1);

    mgc_lvl #(.W(VW + 2), .PIPE(PIPE)) u_l3 (
        .clk (clk),
        .rst (rst),
        .d   ({pg2, qg2, pl2, ql2, rel_c}),
        .q   ({pg_o, qg_o, pl_o, ql_o, rel_o})
    );

    // a bit that says greater (less) forces the flag of its sub-word
    assert_stage_win_gt_R8: assert property (@(posedge clk) disable iff (rst)
        pg2[IDX] |-> rel_c.gt);
    assert_stage_win_lt_R8: assert property (@(posedge clk) disable iff (rst)
        pl2[IDX] |-> rel_c.lt);
    // the flag pair stays exclusive at every bit of the chain
    assert_stage_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(rel_c.gt && rel_c.lt));

endmodule

// File: rtl/mgc_final.sv
// Last majority level: equality = AND(~gt, ~lt); greater and less pass along.
module mgc_final
    import mgc_pkg::*;
#(
    parameter int N    = 8,
    parameter int PIPE = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pg_i,
    input  logic [N-1:0] qg_i,
    input  logic [N-1:0] pl_i,
    input  logic [N-1:0] ql_i,
    input  mgc_rel_t     rel_i,
    output logic         gt,
    output logic         lt,
    output logic         eq
);

    localparam int FILL = (PIPE != 0) ? mgc_levels(N) : 0;
    localparam int CW   = $clog2(FILL + 1) + 1;

    logic eq_c;

    assign eq_c = mgc_and(~rel_i.gt, ~rel_i.lt);

    mgc_lvl #(.W(3), .PIPE(PIPE)) u_lvl (
        .clk (clk),
        .rst (rst),
        .d   ({rel_i.gt, rel_i.lt, eq_c}),
        .q   ({gt, lt, eq})
    );

    // edges since reset, saturating once every level holds real data
    logic [CW-1:0] fill_cnt;

    always_ff @(posedge clk) begin
        if (rst)                         fill_cnt <= '0;
        else if (fill_cnt != CW'(FILL))  fill_cnt <= fill_cnt + 1'b1;
    end

    // per-bit terms from the first level reach the end consistent
    assert_terms_excl_R1: assert property (@(posedge clk) disable iff (rst)
        (pg_i & pl_i) == '0);
    assert_terms_imply_R2: assert property (@(posedge clk) disable iff (rst)
        ((pg_i & ~qg_i) | (pl_i & ~ql_i)) == '0);
    assert_out_excl_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gt, lt}));
    assert_out_full_R3: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt == CW'(FILL)) |-> $onehot({gt, lt, eq}));

endmodule

// File: rtl/mgc_cmp.sv
// N-bit magnitude comparator built from majority gates, rippling from bit 0 up.
module mgc_cmp
    import mgc_pkg::*;
#(
    parameter int N    = 8,
    parameter int PIPE = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic         gt,
    output logic         lt,
    output logic         eq
);

    logic [N-1:0] pg_w [0:N];
    logic [N-1:0] qg_w [0:N];
    logic [N-1:0] pl_w [0:N];
    logic [N-1:0] ql_w [0:N];
    mgc_rel_t     rel_w [0:N];

    // below bit 0 the empty sub-word is neither greater nor less
    assign rel_w[0] = '0;

    mgc_prep #(.N(N), .PIPE(PIPE)) u_prep (
        .clk (clk),
        .rst (rst),
        .a   (a),
        .b   (b),
        .pg  (pg_w[0]),
        .qg  (qg_w[0]),
        .pl  (pl_w[0]),
        .ql  (ql_w[0])
    );

    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            mgc_stage #(.N(N), .IDX(i), .PIPE(PIPE)) u_stage (
                .clk   (clk),
                .rst   (rst),
                .pg_i  (pg_w[i]),
                .qg_i  (qg_w[i]),
                .pl_i  (pl_w[i]),
                .ql_i  (ql_w[i]),
                .rel_i (rel_w[i]),
                .pg_o  (pg_w[i+1]),
                .qg_o  (qg_w[i+1]),
                .pl_o  (pl_w[i+1]),
                .ql_o  (ql_w[i+1]),
                .rel_o (rel_w[i+1])
            );
        end
    endgenerate

    mgc_final #(.N(N), .PIPE(PIPE)) u_final (
        .clk   (clk),
        .rst   (rst),
        .pg_i  (pg_w[N]),
        .qg_i  (qg_w[N]),
        .pl_i  (pl_w[N]),
        .ql_i  (ql_w[N]),
        .rel_i (rel_w[N]),
        .gt    (gt),
        .lt    (lt),
        .eq    (eq)
    );

endmodule

// File: tb/sim_mgc_cmp.sv
`timescale 1ns/100ps
module sim_mgc_cmp;

    localparam int N   = 8;
    localparam int LAT = 3 * N + 2;
    localparam int HD  = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic         gt0, lt0, eq0;
    logic         gt1, lt1, eq1;

    always #2.5 clk = ~clk;

    mgc_cmp #(.N(N), .PIPE(1)) u0 (
        .clk (clk), .rst (rst), .a (a), .b (b),
        .gt (gt0), .lt (lt0), .eq (eq0)
    );

    mgc_cmp #(.N(N), .PIPE(0)) u1 (
        .clk (clk), .rst (rst), .a (a), .b (b),
        .gt (gt1), .lt (lt1), .eq (eq1)
    );

    int           n_run  = 0;
    int           n_fail = 0;
    int           k      = 0;
    bit           done   = 1'b0;
    logic [N-1:0] ha [0:HD-1];
    logic [N-1:0] hb [0:HD-1];

    // expected {gt, lt, eq} from the unsigned relation
    function automatic logic [2:0] ref_rel(input logic [N-1:0] x, input logic [N-1:0] y);
        return {x > y, x < y, x == y};
    endfunction

    task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic chk_rel(input string who, input logic [2:0] got, input logic [2:0] exp);
        chk({"R1 gt ", who}, {2'b00, got[2]}, {2'b00, exp[2]});
        chk({"R2 lt ", who}, {2'b00, got[1]}, {2'b00, exp[1]});
        chk({"R3 eq ", who}, {2'b00, got[0]}, {2'b00, exp[0]});
        chk({"R4 onehot ", who}, 3'($countones(got)), 3'd1);
    endtask

    // one cycle: check outputs at the falling edge, then drive the next pair
    task automatic step(input logic [N-1:0] x, input logic [N-1:0] y,
                        input logic r, input string tag);
        logic [2:0] e;
        @(negedge clk);
        if (rst) begin
            chk("R7 reset clears outputs", {gt0, lt0, eq0}, 3'b000);
        end else if (k >= LAT) begin
            e = ref_rel(ha[(k - LAT) % HD], hb[(k - LAT) % HD]);
            chk_rel("R6 pipelined", {gt0, lt0, eq0}, e);
        end
        rst = r;
        if (r) k = 0;
        a = x;
        b = y;
        if (!r) begin
            ha[k % HD] = x;
            hb[k % HD] = y;
            k++;
        end
        #1;
        e = ref_rel(x, y);
        chk_rel("R5 combinational", {gt1, lt1, eq1}, e);
        if (tag != "") chk(tag, {gt1, lt1, eq1}, e);
    endtask

    task automatic rand_pair(output logic [N-1:0] x, output logic [N-1:0] y);
        int unsigned sel;
        sel = $urandom % 4;
        x = N'($urandom);
        case (sel)
            0:       y = x;
            1:       y = x ^ (N'(1) << ($urandom % N));
            default: y = N'($urandom);
        endcase
    endtask

    initial begin
        logic [N-1:0] x, y;
        logic [N-1:0] ones, top;
        ones = '1;
        top  = N'(1) << (N - 1);
        void'($urandom(32'h5EED_0042));

        for (int i = 0; i < 4; i++) step('0, '0, 1'b1, "");

        // directed corner cases
        step('0,          '0,        1'b0, "R3 all zero");
        step(ones,        ones,      1'b0, "R3 all one");
        step(ones,        '0,        1'b0, "R1 max vs zero");
        step('0,          ones,      1'b0, "R2 zero vs max");
        step(top,         top - 1'b1, 1'b0, "R8 msb decides gt");
        step(top - 1'b1,  top,       1'b0, "R8 msb decides lt");
        step(N'(1),       '0,        1'b0, "R9 lsb decides gt");
        step(ones - 1'b1, ones,      1'b0, "R9 lsb decides lt");
        step(N'(8'hA5),   N'(8'hA5), 1'b0, "R3 pattern equal");
        step(N'(8'h55),   N'(8'hAA), 1'b0, "R2 alternating");

        for (int i = 0; i < 600; i++) begin
            rand_pair(x, y);
            step(x, y, 1'b0, "");
        end

        // reset in mid stream, then refill the pipeline
        for (int i = 0; i < 3; i++) begin
            rand_pair(x, y);
            step(x, y, 1'b1, "");
        end
        for (int i = 0; i < 200; i++) begin
            rand_pair(x, y);
            step(x, y, 1'b0, "");
        end

        // drain: results of the last pairs reach the pipelined outputs
        for (int i = 0; i < LAT; i++) step(top, '0, 1'b0, "");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL R6 watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule